// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block decides which pending exception a processor core services next. It has two kinds of source. Fault sources, called traps here, cannot be masked. Ordinary interrupt sources each have an enable bit and a 3-bit level field. Every source owns a sticky pending flag. A one-cycle request pulse sets the flag, and the flag stays set until the core acknowledges that source. The controller picks the single most urgent pending source and presents it as a vector number together with the level the core should run at while it services that source.

Traps always outrank interrupts. A trap is presented whatever the core's current level is. An interrupt is presented only when its level is strictly above the core's current level. The core answers a presented request with `ack`. That clears the flag of the presented source, and the next candidate appears on the following cycle without a gap. Programming access to the level fields, nesting stacks and context save belong to the surrounding core.

Top module: `pic_vectored`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `req_valid`, `req_vec` and `req_prio` are all 0 and no flag is pending. Whenever `req_valid` is 0, `req_vec` and `req_prio` read 0.
- R2: Trap index t has vector t and level 8+(NUM_TRAPS-1-t), which is 15-t with the default sizes. Any pending trap beats every interrupt. Among pending traps the lowest index wins.
- R3: A pending trap is presented even when `cpu_prio` is 15.
- R4: Interrupt index i has vector NUM_TRAPS+i. Its level is its 3-bit field `irq_prio[3*i+2:3*i]`.
- R5: Among eligible interrupts the highest level wins. On a tie in level, the lowest index wins.
- R6: An interrupt whose enable bit is 0, or whose level field is 0, is never presented. Its flag is kept, and the interrupt is presented once it becomes eligible.
- R7: An interrupt is presented only if its level is strictly greater than `cpu_prio`. If it is not, `req_valid` stays 0.
- R8: `ack` while `req_valid` is 1 clears the presented source's flag. On the very next cycle the next winner is shown, never the acknowledged vector. `ack` while `req_valid` is 0 has no effect.
- R9: A request pulse sampled at clock edge n makes the source's flag visible. The source can then first appear on the outputs after edge n+1. Outputs are registered.
- R10: A pending flag holds across any number of cycles until it is acknowledged. If a set pulse and a clear arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | NUM_TRAPS | One-cycle set pulses for trap flags |
| irq_req | input | NUM_IRQS | One-cycle set pulses for interrupt flags |
| irq_en | input | NUM_IRQS | Per-interrupt enable |
| irq_prio | input | 3*NUM_IRQS | Packed 3-bit level per interrupt; 0 disables |
| cpu_prio | input | 4 | Current core level |
| ack | input | 1 | Core takes the presented request |
| req_valid | output | 1 | A request is presented |
| req_vec | output | clog2(NUM_TRAPS+NUM_IRQS) | Vector of the presented source |
| req_prio | output | 4 | New core level for the presented source |

## Verification
A corrupted pending flag shows at the ports within two cycles. A flag that was lost makes a source drop out of the order. A flag that stuck makes an acknowledged vector come back. A wrong comparison in the ranking chain shows as the wrong vector on the first cycle in which two competing sources are both live. A fault in the acknowledge masking shows on the cycle right after `ack`, as a repeated vector. The bench keeps a cycle model of the flags and compares all three outputs on every cycle. Any divergence is therefore reported in the cycle it first appears.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = PRIO_W + 1;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/pic_pending.sv
module pic_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  // set has precedence over clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr) | set;
  end
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter
  import pic_pkg::*;
#(
  parameter int NT = 8,
  parameter int NI = 118,
  localparam int NS = NT + NI,
  localparam int VW = $clog2(NS)
) (
  input  logic [NS-1:0]        live,
  input  logic [NI-1:0]        irq_en,
  input  logic [NI*PRIO_W-1:0] irq_prio,
  input  lvl_t                 cpu_prio,
  output logic                 hit,
  output logic [VW-1:0]        win_vec,
  output lvl_t                 win_lvl
);
  localparam int TRAP_TOP = (2 ** PRIO_W) + NT - 1;

  logic          t_hit;
  logic [VW-1:0] t_idx;
  lvl_t          t_lvl;
  lvl_t          best;
  logic [VW-1:0] b_idx;
  lvl_t          eff;

  always_comb begin
    t_hit = 1'b0;
    t_idx = '0;
    t_lvl = '0;
    // descending scan: the last hit is the lowest index
    for (int t = NT - 1; t >= 0; t--) begin
      if (live[t]) begin
        t_hit = 1'b1;
        t_idx = VW'(t);
        t_lvl = LVL_W'(TRAP_TOP - t);
      end
    end
    best  = '0;
    b_idx = '0;
    for (int i = NI - 1; i >= 0; i--) begin
      eff = (live[NT+i] && irq_en[i]) ? {1'b0, irq_prio[i*PRIO_W +: PRIO_W]} : '0;
      if (eff != '0 && eff >= best) begin
        best  = eff;
        b_idx = VW'(NT + i);
      end
    end
    if (t_hit) begin
      hit     = 1'b1;
      win_vec = t_idx;
      win_lvl = t_lvl;
    end else begin
      hit     = (best > cpu_prio);
      win_vec = b_idx;
      win_lvl = best;
    end
  end
endmodule

// File: rtl/pic_vectored.sv
module pic_vectored
  import pic_pkg::*;
#(
  parameter int NUM_TRAPS = 8,
  parameter int NUM_IRQS  = 118,
  localparam int NS = NUM_TRAPS + NUM_IRQS,
  localparam int VW = $clog2(NS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_TRAPS-1:0]       trap_req,
  input  logic [NUM_IRQS-1:0]        irq_req,
  input  logic [NUM_IRQS-1:0]        irq_en,
  input  logic [NUM_IRQS*PRIO_W-1:0] irq_prio,
  input  logic [LVL_W-1:0]           cpu_prio,
  input  logic                       ack,
  output logic                       req_valid,
  output logic [VW-1:0]              req_vec,
  output logic [LVL_W-1:0]           req_prio
);
  logic [NS-1:0] pend;
  logic [NS-1:0] clr;
  logic [NS-1:0] live;
  logic          hit;
  logic [VW-1:0] win_vec;
  lvl_t          win_lvl;

  // one-hot clear of the presented source on a taken acknowledge
  for (genvar s = 0; s < NS; s++) begin : g_clr
    assign clr[s] = ack && req_valid && (req_vec == VW'(s));
  end

  pic_pending #(.N(NS)) u_pend (
    .clk  (clk),
    .rst  (rst),
    .set  ({irq_req, trap_req}),
    .clr  (clr),
    .pend (pend)
  );

  // hide the acknowledged source so the next winner shows without a gap
  assign live = pend & ~clr;

  pic_arbiter #(.NT(NUM_TRAPS), .NI(NUM_IRQS)) u_arb (
    .live     (live),
    .irq_en   (irq_en),
    .irq_prio (irq_prio),
    .cpu_prio (cpu_prio),
    .hit      (hit),
    .win_vec  (win_vec),
    .win_lvl  (win_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_vec   <= '0;
      req_prio  <= '0;
    end else begin
      req_valid <= hit;
      req_vec   <= hit ? win_vec : '0;
      req_prio  <= hit ? win_lvl : '0;
    end
  end
endmodule

// File: rtl/pic_vectored_chk.sv
module pic_vectored_chk #(
  parameter int NT = 8,
  parameter int NI = 118,
  localparam int VW = $clog2(NT + NI)
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    cpu_prio,
  input logic          ack,
  input logic          req_valid,
  input logic [VW-1:0] req_vec,
  input logic [3:0]    req_prio
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (req_vec == '0 && req_prio == '0)); // R1

  AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (req_valid && int'(req_vec) < NT) |-> (int'(req_prio) == 8 + NT - 1 - int'(req_vec))); // R2

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (int'(req_vec) < NT + NI)); // R4

  AST_IRQ_LEVEL_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && int'(req_vec) >= NT) |-> (req_prio >= 4'd1 && req_prio <= 4'd7)); // R6

  AST_IRQ_ABOVE_CPU: assert property (@(posedge clk) disable iff (rst)
    (req_valid && int'(req_vec) >= NT && !$rose(req_valid) && $stable(req_vec)) |-> (req_prio > $past(cpu_prio))); // R7

  AST_ACK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ack) |=> !(req_valid && req_vec == $past(req_vec))); // R8
endmodule

bind pic_vectored pic_vectored_chk #(.NT(NUM_TRAPS), .NI(NUM_IRQS)) u_chk (.*);

// File: tb/pic_vectored_test.sv
`timescale 1ns/1ps
module pic_vectored_test;
  localparam int NT = 8;
  localparam int NI = 118;
  localparam int NS = NT + NI;
  localparam int VW = $clog2(NS);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst;
  logic [NT-1:0]     trap_req;
  logic [NI-1:0]     irq_req;
  logic [NI-1:0]     irq_en;
  logic [NI*3-1:0]   irq_prio;
  logic [3:0]        cpu_prio;
  logic              ack;
  logic              req_valid;
  logic [VW-1:0]     req_vec;
  logic [3:0]        req_prio;

  logic       en_a[NI];
  logic [2:0] pr_a[NI];
  bit         mp[NS];
  bit         ev;
  int         evec, elvl;
  int         checks = 0, fails = 0;
  bit         done = 0;

  always_comb
    for (int i = 0; i < NI; i++) begin
      irq_en[i] = en_a[i];
      irq_prio[i*3 +: 3] = pr_a[i];
    end

  pic_vectored uut (
    .clk, .rst, .trap_req, .irq_req, .irq_en, .irq_prio,
    .cpu_prio, .ack, .req_valid, .req_vec, .req_prio
  );

  // expected winner from the requirement text: ascending scans
  function automatic void pick(output bit f, output int v, output int l);
    f = 0; v = 0; l = 0;
    for (int t = 0; t < NT; t++)
      if (mp[t]) begin f = 1; v = t; l = 8 + NT - 1 - t; return; end
    for (int i = 0; i < NI; i++)
      if (mp[NT+i] && en_a[i] && pr_a[i] != 0 && int'(pr_a[i]) > l) begin
        v = NT + i; l = int'(pr_a[i]);
      end
    f = (l > int'(cpu_prio));
    if (!f) begin v = 0; l = 0; end
  endfunction

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic idle_inputs();
    trap_req = '0; irq_req = '0; ack = 1'b0;
  endtask

  // one clock: model update, edge, compare
  task automatic cycle(input string tag);
    bit f; int v, l;
    if (!rst && ack && ev) mp[evec] = 0;
    if (rst) begin
      for (int s = 0; s < NS; s++) mp[s] = 0;
      f = 0; v = 0; l = 0;
    end else pick(f, v, l);
    if (!rst) begin
      for (int t = 0; t < NT; t++) if (trap_req[t]) mp[t] = 1;
      for (int i = 0; i < NI; i++) if (irq_req[i]) mp[NT+i] = 1;
    end
    ev = f; evec = v; elvl = l;
    @(posedge clk); #1;
    checks++;
    if (req_valid !== ev || int'(req_vec) !== evec || int'(req_prio) !== elvl) begin
      fails++;
      $display("FAIL %s: valid/vec/prio = %0b/%0d/%0d expected %0b/%0d/%0d",
               tag, req_valid, req_vec, req_prio, ev, evec, elvl);
    end
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) cycle(tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      report();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst = 1'b1; cpu_prio = 4'd0;
    idle_inputs();
    for (int i = 0; i < NI; i++) begin en_a[i] = 1'b1; pr_a[i] = 3'd0; end
    @(negedge clk);
    idle(3, "R1 reset");
    rst = 1'b0;
    idle(2, "R1 after reset");

    // R9 latency, R4 vector and level, R10 hold
    pr_a[5] = 3'd3; irq_req[5] = 1'b1;
    cycle("R9 set edge");
    idle(4, "R4 R10 presented and held");
    // R7 strict compare
    cpu_prio = 4'd3; idle(2, "R7 equal level blocked");
    cpu_prio = 4'd2; idle(2, "R7 above level");
    // R3 and R2: trap with the core at the top level
    cpu_prio = 4'd15; trap_req[2] = 1'b1; trap_req[6] = 1'b1;
    cycle("R3 trap set");
    idle(2, "R3 R2 trap over level 15");
    ack = 1'b1; cycle("R8 ack trap 2");
    idle(1, "R8 next trap");
    ack = 1'b1; cycle("R8 ack trap 6");
    idle(1, "R8 traps drained");
    cpu_prio = 4'd0;
    // R5 ties and higher level
    pr_a[10] = 3'd5; pr_a[20] = 3'd5; irq_req[20] = 1'b1; irq_req[10] = 1'b1;
    cycle("R5 set tie");
    idle(2, "R5 tie lowest index");
    pr_a[30] = 3'd6; irq_req[30] = 1'b1;
    cycle("R5 set higher");
    idle(2, "R5 higher level wins");
    // R6 disabled and zero level
    en_a[30] = 1'b0; idle(2, "R6 enable off");
    pr_a[10] = 3'd0; idle(2, "R6 level zero");
    en_a[30] = 1'b1; idle(2, "R6 re-enabled");
    // R8 ack without valid
    cpu_prio = 4'd7; idle(1, "R8 masked all");
    ack = 1'b1; cycle("R8 ack while idle");
    cpu_prio = 4'd0; idle(2, "R8 flags kept after idle ack");
    // R10 set and clear together
    ack = 1'b1; irq_req[30 - NT + NT] = 1'b1; cycle("R10 set beats clear");
    idle(2, "R10 re-presented");

    // random phase
    for (int k = 0; k < 4000; k++) begin
      for (int i = 0; i < NI; i++) irq_req[i] = ($urandom_range(0, 79) == 0);
      for (int t = 0; t < NT; t++) trap_req[t] = ($urandom_range(0, 599) == 0);
      ack = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 19) == 0) cpu_prio = 4'($urandom_range(0, 8));
      begin
        int j;
        j = $urandom_range(0, NI - 1);
        pr_a[j] = 3'($urandom_range(0, 7));
        en_a[j] = ($urandom_range(0, 5) != 0);
      end
      cycle("R2 R4 R5 R6 R7 R8 random");
    end
    done = 1;
    report();
  end
endmodule